// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the address and transfer-count state for a set of DMA channels and forms the full transfer address for the channel that the arbiter has picked. Each channel holds a base and a working value for a 16-bit counting address and a 16-bit count. It also holds two 8-bit page bytes that supply the upper address bits, a stop address, and a four-bit mode. The arbiter selects a channel on `act_ch` and pulses `step` once for each access it completes. The engine then moves the working address up or down, or leaves it alone for an I/O port. It counts the transfer down and reports the last transfer with a one-cycle `tc` pulse.

Two mode bits let a channel repeat without software. With auto-reload set, the working address and count are loaded again from their base values on the final step. With ring mode set, a step taken from the stop address goes back to the base address, so the channel circles a buffer. A step that lands on the stop address gives a one-cycle `stop_hit` pulse. Verify-type transfers need nothing special here: they step exactly like data transfers.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset every channel register is zero, and `xfer_addr`, `tc` and `stop_hit` read zero.
- R2: `xfer_addr` is {high page, low page, working address} of channel `act_ch`. A page write takes the low page from `wr_data[7:0]` and the high page from `wr_data[15:8]`. A carry or borrow out of the 16-bit working address never changes a page.
- R3: When mode bit 1 is clear, each accepted step moves the working address by one, modulo 2^16. It moves down when mode bit 0 is set and up when it is clear.
- R4: When mode bit 1 (fixed) is set, an accepted step leaves the address unchanged and still decrements the count.
- R5: A count write of N-1 loads both the base count and the working count. Each accepted step decrements the working count. A step taken at count zero raises `tc` for exactly the cycle after that step's clock edge.
- R6: When mode bit 2 is clear, the channel is finished after the step that raised `tc`. Later steps change no address and raise no event until the count is written again.
- R7: When mode bit 2 (auto-reload) is set, the step taken at count zero reloads the working address from the base address and the working count from the base count.
- R8: A step on a non-fixed channel whose new working address equals the stop value raises `stop_hit` for one cycle. The pulse comes in the cycle after the step.
- R9: When mode bit 3 (ring) is set and mode bit 1 is clear, a step taken while the working address equals the stop value loads the base address instead of moving by one.
- R10: Register select codes on `wr_sel` are: 0 base address, 1 count, 2 pages, 3 stop, 4 mode (data bits 3:0). Codes 5 to 7 change nothing. A base address write loads both the base and the working address.
- R11: A write to the selected channel in the same cycle as `step` takes effect, and the step is dropped with no event.
- R12: A step changes only the channel named by `act_ch`.
- R13: When both the auto-reload and the ring reload apply on one step, the auto-reload takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 16 | Write data |
| step | input | 1 | One access completed on `act_ch` |
| act_ch | input | 2 | Channel selected by the arbiter |
| xfer_addr | output | 32 | Full transfer address of `act_ch` |
| tc | output | 1 | Terminal count pulse |
| stop_hit | output | 1 | Stop address reached pulse |

## Verification
The assertions are checked on every cycle. They cover the following: pages never move on a step, a fixed-address channel holds its address, a non-reloading step changes the address by exactly one in the programmed direction, `tc` and `stop_hit` only follow an accepted step, and a finished channel stays frozen. Some behaviour can only be shown by the bench's scenarios, because it depends on values programmed several cycles earlier:
- the exact cycle of terminal count after N-1 is loaded,
- reload values under auto-reload and ring wrap,
- the precedence between them,
- a write colliding with a step,
- independence between channels.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_CNT  = 3'd1,
    SEL_PAGE = 3'd2,
    SEL_STOP = 3'd3,
    SEL_MODE = 3'd4
  } reg_sel_e;

  // bit 0 dec, bit 1 fixed, bit 2 auto-reload, bit 3 ring
  typedef struct packed {
    logic ring;
    logic autold;
    logic fixed;
    logic dec;
  } chan_mode_t;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          step_en,
  output logic [AW-1:0] cur_o,
  output logic [PW-1:0] lo_o,
  output logic [PW-1:0] hi_o,
  output chan_mode_t    mode_o,
  output logic          done_o,
  output logic          tc_evt,
  output logic          stop_evt,
  output logic          reload_evt
);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input logic down);
    return down ? AW'(a - 1'b1) : AW'(a + 1'b1);
  endfunction

  logic [AW-1:0] base_a, cur_a, stop_a, next_a;
  logic [CW-1:0] base_c, cur_c;
  logic [PW-1:0] lo_pg, hi_pg;
  chan_mode_t    mode;
  logic          done;
  logic          take, cnt_zero, ring_wrap, auto_rl;

  always_comb begin
    take      = step_en && !done && !wr_en;
    cnt_zero  = (cur_c == '0);
    ring_wrap = mode.ring && !mode.fixed && (cur_a == stop_a);
    auto_rl   = cnt_zero && mode.autold;
    if (auto_rl)         next_a = base_a;
    else if (mode.fixed) next_a = cur_a;
    else if (ring_wrap)  next_a = base_a;
    else                 next_a = bump(cur_a, mode.dec);
    tc_evt     = take && cnt_zero;
    stop_evt   = take && !mode.fixed && (next_a == stop_a);
    reload_evt = take && (auto_rl || ring_wrap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0; cur_a <= '0; stop_a <= '0;
      base_c <= '0; cur_c <= '0;
      lo_pg  <= '0; hi_pg <= '0;
      mode   <= '0; done  <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_BASE: begin base_a <= wr_data; cur_a <= wr_data; end
        SEL_CNT:  begin base_c <= wr_data[CW-1:0]; cur_c <= wr_data[CW-1:0]; done <= 1'b0; end
        SEL_PAGE: begin lo_pg <= wr_data[PW-1:0]; hi_pg <= wr_data[2*PW-1:PW]; end
        SEL_STOP: stop_a <= wr_data;
        SEL_MODE: mode <= chan_mode_t'(wr_data[3:0]);
        default:  ;
      endcase
    end else if (take) begin
      cur_a <= next_a;
      cur_c <= auto_rl ? base_c : CW'(cur_c - 1'b1);
      if (cnt_zero && !mode.autold) done <= 1'b1;
    end
  end

  assign cur_o  = cur_a;
  assign lo_o   = lo_pg;
  assign hi_o   = hi_pg;
  assign mode_o = mode;
  assign done_o = done;

endmodule

// File: rtl/dma_sel_mux.sv
module dma_sel_mux
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int PW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0][AW-1:0] cur_v,
  input  logic [NCH-1:0][PW-1:0] lo_v,
  input  logic [NCH-1:0][PW-1:0] hi_v,
  input  chan_mode_t [NCH-1:0]   mode_v,
  input  logic [NCH-1:0]         done_v,
  input  logic [NCH-1:0]         reload_v,
  input  logic [CHW-1:0]         sel,
  output logic [AW+2*PW-1:0]     addr_o,
  output chan_mode_t             mode_o,
  output logic                   done_o,
  output logic                   reload_o
);

  always_comb begin
    addr_o   = {hi_v[sel], lo_v[sel], cur_v[sel]};
    mode_o   = mode_v[sel];
    done_o   = done_v[sel];
    reload_o = reload_v[sel];
  end

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PW  = 8,
  localparam int CHW = $clog2(NCH),
  localparam int FW  = AW + 2*PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [2:0]     wr_sel,
  input  logic [AW-1:0]  wr_data,
  input  logic           step,
  input  logic [CHW-1:0] act_ch,
  output logic [FW-1:0]  xfer_addr,
  output logic           tc,
  output logic           stop_hit
);

  logic [NCH-1:0][AW-1:0] cur_v;
  logic [NCH-1:0][PW-1:0] lo_v, hi_v;
  chan_mode_t [NCH-1:0]   mode_v;
  logic [NCH-1:0]         done_v, tc_v, stop_v, reload_v;

  // named events for the checker
  chan_mode_t act_mode;
  logic       act_done, act_reload, act_fixed, act_dec, step_take;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW), .PW(PW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en && (wr_ch == CHW'(i))),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .step_en    (step && (act_ch == CHW'(i))),
      .cur_o      (cur_v[i]),
      .lo_o       (lo_v[i]),
      .hi_o       (hi_v[i]),
      .mode_o     (mode_v[i]),
      .done_o     (done_v[i]),
      .tc_evt     (tc_v[i]),
      .stop_evt   (stop_v[i]),
      .reload_evt (reload_v[i])
    );
  end

  dma_sel_mux #(.NCH(NCH), .AW(AW), .PW(PW)) u_mux (
    .cur_v    (cur_v),
    .lo_v     (lo_v),
    .hi_v     (hi_v),
    .mode_v   (mode_v),
    .done_v   (done_v),
    .reload_v (reload_v),
    .sel      (act_ch),
    .addr_o   (xfer_addr),
    .mode_o   (act_mode),
    .done_o   (act_done),
    .reload_o (act_reload)
  );

  assign act_fixed = act_mode.fixed;
  assign act_dec   = act_mode.dec;
  assign step_take = step && !act_done && !(wr_en && (wr_ch == act_ch));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc       <= 1'b0;
      stop_hit <= 1'b0;
    end else begin
      tc       <= |tc_v;
      stop_hit <= |stop_v;
    end
  end

endmodule

// File: rtl/dma_addr_engine_chk.sv
module dma_addr_engine_chk #(
  parameter int AW  = 16,
  parameter int PW  = 8,
  parameter int CHW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              step,
  input logic [CHW-1:0]    act_ch,
  input logic [AW+2*PW-1:0] xfer_addr,
  input logic              tc,
  input logic              stop_hit,
  input logic              step_take,
  input logic              act_done,
  input logic              act_fixed,
  input logic              act_dec,
  input logic              act_reload
);

  // R2: pages untouched by stepping
  a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && !wr_en) |=> ($stable(act_ch) -> $stable(xfer_addr[AW+2*PW-1:AW])));

  // R3: unit step in the programmed direction
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && !wr_en && !act_fixed && !act_reload) |=>
      ($stable(act_ch) -> (xfer_addr[AW-1:0] == ($past(act_dec)
        ? AW'($past(xfer_addr[AW-1:0]) - 1'b1)
        : AW'($past(xfer_addr[AW-1:0]) + 1'b1)))));

  // R4: fixed port address
  a_r4_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && !wr_en && act_fixed && !act_reload) |=>
      ($stable(act_ch) -> $stable(xfer_addr)));

  // R5: terminal count only follows an accepted step
  a_r5_tc_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(step_take));

  // R6: finished channel is frozen
  a_r6_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act_done && !wr_en) |=> (!tc && !stop_hit && ($stable(act_ch) -> $stable(xfer_addr))));

  // R8: stop pulse only follows an accepted step
  a_r8_stop_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |-> $past(step_take));

endmodule

bind dma_addr_engine dma_addr_engine_chk #(.AW(AW), .PW(PW), .CHW(CHW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .step       (step),
  .act_ch     (act_ch),
  .xfer_addr  (xfer_addr),
  .tc         (tc),
  .stop_hit   (stop_hit),
  .step_take  (step_take),
  .act_done   (act_done),
  .act_fixed  (act_fixed),
  .act_dec    (act_dec),
  .act_reload (act_reload)
);

// File: tb/dma_addr_engine_test.sv
`timescale 1ns/1ps
module dma_addr_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        step = 1'b0;
  logic [1:0]  act_ch = '0;
  logic [31:0] xfer_addr;
  logic        tc, stop_hit;

  int vectors = 0;
  int misses  = 0;

  // bench model
  logic [15:0] m_base[4], m_cur[4], m_bc[4], m_cc[4], m_stop[4];
  logic [7:0]  m_lo[4], m_hi[4];
  logic [3:0]  m_mode[4];
  logic        m_done[4];
  logic        m_tc, m_stop_ev;

  always #2.5 clk = ~clk;

  dma_addr_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .step(step), .act_ch(act_ch),
    .xfer_addr(xfer_addr), .tc(tc), .stop_hit(stop_hit)
  );

  function automatic logic [15:0] moved(input logic [15:0] a, input logic [3:0] md,
                                        input logic [15:0] base, input logic [15:0] stp);
    if (md[1]) return a;                       // fixed port
    if (md[3] && a == stp) return base;        // ring wrap
    return md[0] ? a - 16'd1 : a + 16'd1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_cur[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_stop[i] = 0;
      m_lo[i] = 0; m_hi[i] = 0; m_mode[i] = 0; m_done[i] = 0;
    end
    m_tc = 0; m_stop_ev = 0;
  endtask

  task automatic cyc(input logic we, input int wc, input int ws, input logic [15:0] wd,
                     input logic st, input int ac, input string tag);
    logic [15:0] na;
    wr_en = we; wr_ch = 2'(wc); wr_sel = 3'(ws); wr_data = wd; step = st; act_ch = 2'(ac);
    @(posedge clk);
    m_tc = 0; m_stop_ev = 0;
    if (st && !m_done[ac] && !(we && wc == ac)) begin
      if (m_cc[ac] == 0) m_tc = 1;
      if (m_cc[ac] == 0 && m_mode[ac][2]) begin
        na = m_base[ac];
        m_cc[ac] = m_bc[ac];
      end else begin
        na = moved(m_cur[ac], m_mode[ac], m_base[ac], m_stop[ac]);
        if (m_cc[ac] == 0) m_done[ac] = 1;
        m_cc[ac] = m_cc[ac] - 16'd1;
      end
      m_stop_ev = !m_mode[ac][1] && (na == m_stop[ac]);
      m_cur[ac] = na;
    end
    if (we) begin
      case (ws)
        0: begin m_base[wc] = wd; m_cur[wc] = wd; end
        1: begin m_bc[wc] = wd; m_cc[wc] = wd; m_done[wc] = 0; end
        2: begin m_lo[wc] = wd[7:0]; m_hi[wc] = wd[15:8]; end
        3: m_stop[wc] = wd;
        4: m_mode[wc] = wd[3:0];
        default: ;
      endcase
    end
    @(negedge clk);
    check({tag, " addr"}, xfer_addr, {m_hi[ac], m_lo[ac], m_cur[ac]});
    check({tag, " tc"}, 32'(tc), 32'(m_tc));
    check({tag, " stop"}, 32'(stop_hit), 32'(m_stop_ev));
  endtask

  task automatic wr(input int c, input int s, input logic [15:0] d, input string tag);
    cyc(1'b1, c, s, d, 1'b0, c, tag);
  endtask

  task automatic stp(input int c, input string tag);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, c, tag);
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset addr", xfer_addr, 32'h0);
    check("R1 reset tc", 32'(tc), 32'h0);

    // R2 R3 R5 R6: count up with pages, terminal count, then frozen
    wr(0, 2, 16'h0025, "R2");
    wr(0, 0, 16'h1000, "R10");
    wr(0, 1, 16'd3, "R5");
    wr(0, 4, 16'h0, "R10");
    for (int k = 0; k < 4; k++) stp(0, "R5");
    stp(0, "R6"); stp(0, "R6");
    wr(0, 6, 16'hFFFF, "R10 unused code");
    stp(0, "R6");

    // R2 carry leaves pages alone
    wr(1, 2, 16'h12AB, "R2");
    wr(1, 0, 16'hFFFE, "R2");
    wr(1, 1, 16'd5, "R2");
    stp(1, "R2"); stp(1, "R2"); stp(1, "R2");

    // R3 down with borrow
    wr(2, 4, 16'h0001, "R3");
    wr(2, 0, 16'h0001, "R3");
    wr(2, 1, 16'd4, "R3");
    stp(2, "R3"); stp(2, "R3"); stp(2, "R3");

    // R4 fixed port
    wr(3, 4, 16'h0002, "R4");
    wr(3, 0, 16'h0378, "R4");
    wr(3, 1, 16'd2, "R4");
    stp(3, "R4"); stp(3, "R4"); stp(3, "R4");

    // R7 auto reload
    wr(0, 4, 16'h0004, "R7");
    wr(0, 0, 16'h2000, "R7");
    wr(0, 1, 16'd1, "R7");
    for (int k = 0; k < 5; k++) stp(0, "R7");

    // R8 R9 ring buffer
    wr(1, 4, 16'h0008, "R9");
    wr(1, 0, 16'h0100, "R9");
    wr(1, 3, 16'h0102, "R8");
    wr(1, 1, 16'd20, "R9");
    for (int k = 0; k < 6; k++) stp(1, "R9");

    // R13 both reloads at once
    wr(2, 4, 16'h000C, "R13");
    wr(2, 0, 16'h0040, "R13");
    wr(2, 3, 16'h0041, "R13");
    wr(2, 1, 16'd1, "R13");
    stp(2, "R13"); stp(2, "R13"); stp(2, "R13");

    // R11 collision, R12 independence
    cyc(1'b1, 1, 3, 16'h7777, 1'b1, 1, "R11");
    cyc(1'b1, 2, 3, 16'h0000, 1'b1, 1, "R12");
    stp(3, "R12");
    cyc(1'b0, 0, 0, 16'h0, 1'b0, 0, "R12");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int c, s, ac;
      logic [15:0] d;
      c  = int'($urandom_range(0, 3));
      ac = int'($urandom_range(0, 3));
      s  = int'($urandom_range(0, 5));
      d  = 16'($urandom);
      if (s == 1) d = 16'($urandom_range(0, 6));
      if (s == 3) d = m_cur[c] + 16'($urandom_range(0, 4)) - 16'd2;
      if ($urandom_range(0, 9) < 2)
        cyc(1'b1, c, s, d, $urandom_range(0, 1) == 1, ac, "R12 random");
      else
        cyc(1'b0, 0, 0, 16'h0, $urandom_range(0, 9) < 8, ac, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule